// File: doc/BRIEF.md
# Indirect-Addressed Asynchronous Host Port

This block is the slave end of an 8-bit asynchronous host bus. The bus has chip select, active-low read and write strobes and a 2-bit location select. The host sees four locations. One is a FIFO data port, which works only while FIFO mode is enabled. Two are write-only bytes that together form a 10-bit pointer. The last is a data window onto a 10-bit internal register space. To reach a register, the host loads the pointer and then reads or writes the window. The pointer keeps its value across window accesses, so repeated accesses to one register need no pointer reload.

The host side has no clock. Chip select and both strobes pass through a multi-flop synchronizer into the internal clock domain. A sequencer then runs a strobe/acknowledge handshake and turns each host access into at most one single-cycle request on a simple internal interface. That interface serves both the register array and the FIFO. Read responses are expected one clock after the request. On the FIFO location, the acknowledge is also held back while the FIFO cannot accept or supply a byte.

Top module: `hostIndexPort`

## Requirements
- R1: A write to location 2'b01 loads pointer bits [9:8] from host data bits [1:0]. A write to location 2'b10 loads pointer bits [7:0]. Each write leaves the other pointer byte unchanged.
- R2: A write to location 2'b11 produces exactly one internal register write, with `regAddr` equal to the pointer and `regWrData` equal to the host byte.
- R3: A read of location 2'b11 produces exactly one internal register read at the pointer address. The response sampled one clock later is driven on `hostDataOut`.
- R4: The pointer never changes because of a data-window access. Back-to-back window accesses all use the same address.
- R5: `hostAck` is 0 after reset. It rises only after an active strobe has been seen through the synchronizer, at least 3 clocks after the strobe falls. It stays high while the strobe is held low, and it falls after the strobe release is seen.
- R6: `hostDataOe` is 1 only during an acknowledged read. It holds with stable data until the RD release has been seen, and it is 0 at all other times.
- R7: A write request is issued only after the rising edge of WR has been seen, never while WR is still low. It carries the data byte held during the strobe.
- R8: With `fifoModeEn`=1, location 2'b00 turns a write into one `fifoWrEn` pulse and a read into one `fifoRdEn` pulse. `hostAck` is withheld while `fifoFull` is 1 on a write, or while `fifoEmpty` is 1 on a read.
- R9: With `fifoModeEn`=0, a write to location 2'b00 issues no request, and a read of it returns 8'h00. Reads of the write-only locations 2'b01 and 2'b10 return 8'h00.
- R10: Every internal request (`regWrEn`, `regRdEn`, `fifoWrEn`, `fifoRdEn`) is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low reset |
| hostCsN | input | 1 | Host chip select, active low, asynchronous |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| hostAddr | input | 2 | Location select |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Host read data |
| hostDataOe | output | 1 | Output enable for the host data bus |
| hostAck | output | 1 | Handshake acknowledge, active high |
| fifoModeEn | input | 1 | Enables the FIFO location |
| regAddr | output | 10 | Internal register address (the pointer) |
| regWrEn | output | 1 | Internal register write pulse |
| regRdEn | output | 1 | Internal register read pulse |
| regWrData | output | 8 | Internal register write data |
| regRdData | input | 8 | Register read response, valid one clock after `regRdEn` |
| fifoWrEn | output | 1 | FIFO push pulse |
| fifoRdEn | output | 1 | FIFO pop pulse |
| fifoWrData | output | 8 | FIFO push data |
| fifoRdData | input | 8 | FIFO pop response, valid one clock after `fifoRdEn` |
| fifoFull | input | 1 | FIFO cannot accept a byte |
| fifoEmpty | input | 1 | FIFO has no byte to give |

## Verification
The hardest state to reach from the ports is a strobe held low while the FIFO is busy. In that state the acknowledge must stay low for many cycles and then complete cleanly. The bench's FIFO model has force inputs for full and empty. It holds one of them through a 20-cycle strobe, checks that no acknowledge appears, then releases it and expects the transfer to finish. A slow host that holds the strobe past the acknowledge is also modelled. During the hold, the bench checks that the read data stays driven and that no write request leaks out before WR is released.

// File: rtl/hip_pkg.sv
package hip_pkg;
  typedef enum logic [1:0] {
    LOC_FIFO   = 2'b00,
    LOC_PTR_HI = 2'b01,
    LOC_PTR_LO = 2'b10,
    LOC_WIN    = 2'b11
  } hipLoc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_GRAB,
    ST_ACK
  } hipState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    issueRd;
    logic    grabRd;
    logic    holdWrData;
    logic    commitWr;
    logic    driveBus;
    hipLoc_e loc;
  } hipStrobe_t;
endpackage

// File: rtl/hipSync.sv
module hipSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hipCtrl.sv
module hipCtrl
  import hip_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csSyncN,
  input  logic       rdSyncN,
  input  logic       wrSyncN,
  input  logic [1:0] hostAddr,
  input  logic       fifoModeEn,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  output hipStrobe_t strb,
  output logic       hostAck
);
  hipState_e state, nextState;
  hipLoc_e   locQ;
  logic      isRead;
  logic      rdAct, wrAct, startAcc, strobeHeld, fifoBusy;

  assign rdAct      = !csSyncN && !rdSyncN;
  assign wrAct      = !csSyncN && !wrSyncN;
  assign startAcc   = rdAct ^ wrAct;
  assign strobeHeld = isRead ? rdAct : wrAct;
  assign fifoBusy   = (locQ == LOC_FIFO) && fifoModeEn && (isRead ? fifoEmpty : fifoFull);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      locQ   <= LOC_FIFO;
      isRead <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && startAcc) begin
        locQ   <= hipLoc_e'(hostAddr);
        isRead <= rdAct;
      end
    end
  end

  always_comb begin
    nextState       = state;
    strb            = '0;
    strb.loc        = locQ;
    unique case (state)
      ST_IDLE: if (startAcc) nextState = ST_WAIT;
      ST_WAIT: begin
        if (!strobeHeld) nextState = ST_IDLE;
        else if (!fifoBusy) begin
          if (isRead) begin
            strb.issueRd = 1'b1;
            nextState    = ST_GRAB;
          end else begin
            nextState = ST_ACK;
          end
        end
      end
      ST_GRAB: begin
        strb.grabRd = 1'b1;
        nextState   = ST_ACK;
      end
      ST_ACK: begin
        strb.driveBus   = isRead;
        strb.holdWrData = !isRead && strobeHeld;
        if (!strobeHeld) begin
          strb.commitWr = !isRead;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign hostAck = (state == ST_ACK);

  // R5
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAck) |-> $past(rdAct || wrAct));
  // R5
  ack_drop_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostAck) |-> $past(!strobeHeld));
  // R8
  ack_fifo_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && fifoBusy) |=> !hostAck);
endmodule

// File: rtl/hipDatapath.sv
module hipDatapath
  import hip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  hipStrobe_t        strb,
  input  logic              fifoModeEn,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              fifoWrEn,
  output logic              fifoRdEn,
  output logic [DATA_W-1:0] fifoWrData,
  input  logic [DATA_W-1:0] fifoRdData
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0]   ptrHi;
  logic [DATA_W-1:0] ptrLo;
  logic [DATA_W-1:0] wrHold;
  logic [DATA_W-1:0] rdLatch;
  logic              fifoOn, winSel;

  assign fifoOn = (strb.loc == LOC_FIFO) && fifoModeEn;
  assign winSel = (strb.loc == LOC_WIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHi   <= '0;
      ptrLo   <= '0;
      wrHold  <= '0;
      rdLatch <= '0;
    end else begin
      if (strb.holdWrData) wrHold <= hostDataIn;
      if (strb.commitWr && strb.loc == LOC_PTR_HI) ptrHi <= wrHold[HI_W-1:0];
      if (strb.commitWr && strb.loc == LOC_PTR_LO) ptrLo <= wrHold;
      if (strb.grabRd) begin
        if (winSel)      rdLatch <= regRdData;
        else if (fifoOn) rdLatch <= fifoRdData;
        else             rdLatch <= '0;
      end
    end
  end

  assign regAddr     = {ptrHi, ptrLo};
  assign regWrEn     = strb.commitWr && winSel;
  assign regRdEn     = strb.issueRd && winSel;
  assign fifoWrEn    = strb.commitWr && fifoOn;
  assign fifoRdEn    = strb.issueRd && fifoOn;
  assign regWrData   = wrHold;
  assign fifoWrData  = wrHold;
  assign hostDataOut = rdLatch;
  assign hostDataOe  = strb.driveBus;

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> !fifoFull);
  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |-> !fifoEmpty);
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || fifoWrEn) |=> !(regWrEn || fifoWrEn));
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn || fifoRdEn) |=> !(regRdEn || fifoRdEn));
  // R4
  ptr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |=> $stable(regAddr));
endmodule

// File: rtl/hostIndexPort.sv
module hostIndexPort
  import hip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              hostAck,
  input  logic              fifoModeEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              fifoWrEn,
  output logic              fifoRdEn,
  output logic [DATA_W-1:0] fifoWrData,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic              fifoFull,
  input  logic              fifoEmpty
);
  logic [2:0] strobeSync;
  hipStrobe_t strb;

  hipSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b111)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({hostCsN, hostRdN, hostWrN}),
    .syncOut(strobeSync)
  );

  hipCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .csSyncN(strobeSync[2]), .rdSyncN(strobeSync[1]), .wrSyncN(strobeSync[0]),
    .hostAddr(hostAddr), .fifoModeEn(fifoModeEn),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .strb(strb), .hostAck(hostAck)
  );

  hipDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .fifoModeEn(fifoModeEn),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .fifoWrEn(fifoWrEn), .fifoRdEn(fifoRdEn),
    .fifoWrData(fifoWrData), .fifoRdData(fifoRdData)
  );

  // R6
  oe_only_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> hostAck);
endmodule

// File: tb/tb_hostIndexPort.sv
module tb_hostIndexPort;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN;
  logic       hostCsN, hostRdN, hostWrN;
  logic [1:0] hostAddr;
  logic [7:0] hostDataIn, hostDataOut;
  logic       hostDataOe, hostAck, fifoModeEn;
  logic [9:0] regAddr;
  logic       regWrEn, regRdEn, fifoWrEn, fifoRdEn;
  logic [7:0] regWrData, regRdData, fifoWrData, fifoRdData;
  logic       fifoFull, fifoEmpty;
  logic       forceFull, forceEmpty;

  hostIndexPort dut (.*);

  // register array model, one-clock read latency
  logic [7:0] mem [1024];
  always @(posedge clk) begin
    if (regWrEn) mem[regAddr] <= regWrData;
    if (regRdEn) regRdData <= mem[regAddr];
  end

  // FIFO model, depth 4
  logic [7:0] fmem [4];
  int wp = 0, rp = 0, cnt = 0;
  assign fifoFull  = forceFull || (cnt == 4);
  assign fifoEmpty = forceEmpty || (cnt == 0);
  always @(posedge clk) begin
    if (fifoWrEn) begin fmem[wp] <= fifoWrData; wp <= (wp + 1) % 4; end
    if (fifoRdEn) begin fifoRdData <= fmem[rp]; rp <= (rp + 1) % 4; end
    cnt <= cnt + (fifoWrEn ? 1 : 0) - (fifoRdEn ? 1 : 0);
  end

  typedef struct { int kind; logic [9:0] addr; logic [7:0] data; } exp_t;
  exp_t expQ[$];
  int vectors = 0, miscompares = 0, evCount = 0;
  logic prevWr = 1'b0, prevRd = 1'b0;

  function automatic void chk(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  function automatic void popCmp(int kind, logic [9:0] a, logic [7:0] d, string tag);
    exp_t e;
    if (expQ.size() == 0) begin
      chk(0, tag, "unexpected event kind", kind, -1);
      return;
    end
    e = expQ.pop_front();
    chk(e.kind == kind && e.addr == a && e.data == d, tag, "event kind/addr/data",
        {kind[3:0], 2'b0, a, d}, {e.kind[3:0], 2'b0, e.addr, e.data});
  endfunction

  function automatic void push(int kind, logic [9:0] a, logic [7:0] d);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d;
    expQ.push_back(e);
  endfunction

  // monitor: internal requests against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn)  begin popCmp(0, regAddr, regWrData, "R2"); evCount++; end
      if (fifoWrEn) begin popCmp(1, 10'd0, fifoWrData, "R8"); evCount++; end
      if (regRdEn)  popCmp(3, regAddr, 8'd0, "R3");
      if (regWrEn || fifoWrEn) chk(!prevWr, "R10", "write pulse width", 2, 1);
      if (regRdEn || fifoRdEn) chk(!prevRd, "R10", "read pulse width", 2, 1);
      prevWr = regWrEn || fifoWrEn;
      prevRd = regRdEn || fifoRdEn;
    end
  end

  task automatic hostOp(input bit isRd, input logic [1:0] a, input logic [7:0] d,
                        input int extra, input int holdOff, input string tag);
    int lat = 0;
    int evStart;
    logic [7:0] q;
    @(negedge clk);
    hostAddr = a; hostDataIn = d; hostCsN = 1'b0;
    @(negedge clk);
    if (isRd) hostRdN = 1'b0; else hostWrN = 1'b0;
    evStart = evCount;
    if (holdOff > 0) begin
      int seen = 0;
      repeat (holdOff) begin @(negedge clk); if (hostAck) seen++; end
      chk(seen == 0, tag, "ack withheld while FIFO busy", seen, 0);
      forceFull = 1'b0; forceEmpty = 1'b0;
    end
    while (!hostAck && lat < 2000) begin @(negedge clk); lat++; end
    chk(hostAck && (holdOff > 0 || lat >= 3), "R5", "ack latency after strobe", lat, 3);
    q = hostDataOut;
    if (isRd) begin
      chk(hostDataOe, "R6", "bus driven during acked read", hostDataOe, 1);
      popCmp(2, 10'd0, q, tag);
    end
    repeat (extra) @(negedge clk);
    chk(hostAck, "R5", "ack held while strobe low", hostAck, 1);
    if (isRd) chk(hostDataOe && hostDataOut == q, "R6", "read data stable until release", hostDataOut, q);
    else chk(evCount == evStart, "R7", "no write request before WR rises", evCount, evStart);
    hostRdN = 1'b1; hostWrN = 1'b1;
    lat = 0;
    while (hostAck && lat < 2000) begin @(negedge clk); lat++; end
    chk(!hostAck && !hostDataOe, "R5", "ack and enable drop after release", {hostAck, hostDataOe}, 0);
    hostCsN = 1'b1;
    @(negedge clk);
  endtask

  task automatic rdExp(input logic [1:0] a, input logic [7:0] e, input int extra, input string tag);
    push(2, 10'd0, e);
    hostOp(1'b1, a, 8'h00, extra, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
    rstN = 1'b0; hostCsN = 1'b1; hostRdN = 1'b1; hostWrN = 1'b1;
    hostAddr = 2'b00; hostDataIn = 8'h00; fifoModeEn = 1'b0;
    forceFull = 1'b0; forceEmpty = 1'b0;
    repeat (3) @(negedge clk);
    chk(!hostAck && !hostDataOe, "R5", "reset ack/enable", {hostAck, hostDataOe}, 0);
    chk(!regWrEn && !regRdEn, "R10", "no request in reset", {regWrEn, regRdEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 pointer load, R2 window write, R4 no increment
    hostOp(1'b0, 2'b01, 8'hFE, 0, 0, "R1");
    hostOp(1'b0, 2'b10, 8'h34, 0, 0, "R1");
    push(0, 10'h234, 8'hA5);
    hostOp(1'b0, 2'b11, 8'hA5, 0, 0, "R2");
    push(0, 10'h234, 8'h3C);
    hostOp(1'b0, 2'b11, 8'h3C, 3, 0, "R4");
    // R3 window read, slow host (R6)
    push(3, 10'h234, 8'd0);
    rdExp(2'b11, 8'h3C, 5, "R3");
    push(3, 10'h234, 8'd0);
    rdExp(2'b11, 8'h3C, 0, "R4");
    // R1 lower byte alone
    hostOp(1'b0, 2'b10, 8'h07, 0, 0, "R1");
    push(3, 10'h207, 8'd0);
    rdExp(2'b11, 8'h07 ^ 8'h5A, 0, "R1");
    // R1 upper byte alone
    hostOp(1'b0, 2'b01, 8'h01, 0, 0, "R1");
    push(0, 10'h107, 8'h99);
    hostOp(1'b0, 2'b11, 8'h99, 0, 0, "R1");
    // R9 write-only locations read as zero
    rdExp(2'b01, 8'h00, 0, "R9");
    rdExp(2'b10, 8'h00, 2, "R9");
    // R9 FIFO location disabled
    hostOp(1'b0, 2'b00, 8'h11, 0, 0, "R9");
    chk(cnt == 0, "R9", "disabled FIFO write has no effect", cnt, 0);
    rdExp(2'b00, 8'h00, 0, "R9");

    // R8 FIFO path
    fifoModeEn = 1'b1;
    push(1, 10'd0, 8'hB1);
    hostOp(1'b0, 2'b00, 8'hB1, 0, 0, "R8");
    push(1, 10'd0, 8'hB2);
    hostOp(1'b0, 2'b00, 8'hB2, 0, 0, "R8");
    rdExp(2'b00, 8'hB1, 0, "R8");
    // R8 held off while full
    forceFull = 1'b1;
    push(1, 10'd0, 8'hC3);
    hostOp(1'b0, 2'b00, 8'hC3, 0, 20, "R8");
    chk(cnt == 2, "R8", "FIFO occupancy after held write", cnt, 2);
    rdExp(2'b00, 8'hB2, 0, "R8");
    // R8 held off while empty
    forceEmpty = 1'b1;
    push(2, 10'd0, 8'hC3);
    hostOp(1'b1, 2'b00, 8'h00, 0, 20, "R8");
    chk(cnt == 0, "R8", "FIFO drained", cnt, 0);
    chk(expQ.size() == 0, "R2", "scoreboard empty at end", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule